// File: doc/BRIEF.md
# Priority-Tagged Deferred Issue Scheduler

This block sits between decode and execute in a single-issue, in-order core. Every decoded instruction arrives with a one-bit priority tag that the compiler has set. Tagged instructions (high priority) issue in the cycle they are accepted. Untagged instructions (low priority) do not issue at once. Their destination register gets a fresh physical register from an external free list, and their operands are captured through a rename table. They then wait in program order in a deferral buffer.

A mode controller decides when the waiting work runs. It has three named states. MODE_HI is the reset state and the normal state. In MODE_HI only high-priority instructions issue, and low-priority ones are parked. MODE_LO drains the buffer one entry per cycle while a data-cache miss is outstanding. MODE_FLUSH drains the whole buffer after a flush instruction, with no need for a miss.

The transitions are as follows:
- HI_TO_FLUSH: a flush is accepted while the buffer holds entries.
- HI_TO_LO: the miss input rises while the buffer holds entries, and no flush is accepted in that cycle.
- LO_MISS_DONE: the miss input drops, so the controller returns to MODE_HI.
- LO_EMPTY: the last entry issues while the miss is still pending, so the controller returns to MODE_HI.
- FLUSH_DONE: the last entry issues, so the controller returns to MODE_HI.

Top module: `prio_defer_sched`

## Requirements
- R1: After reset the mode output reads 0 (MODE_HI), nothing issues, and the buffer is empty. An empty buffer means a low-priority instruction is accepted when a free register is offered. The rename table maps architectural register i to physical register i.
- R2: In MODE_HI, an accepted instruction with `in_hi`=1 and `in_flush`=0 issues in the same cycle with `iss_lo`=0. Its source and destination physical registers are read through the rename table. This means a register last written by a still-buffered low-priority instruction reads as that instruction's new physical register.
- R3: In MODE_HI, an accepted instruction with `in_hi`=0 and `in_flush`=0 does not issue. It asserts `fl_take`, and from the next cycle the table maps its destination to `fl_preg`. Its buffer entry records three values: `fl_preg` as destination, the source mapping from before the update, and the previous mapping of the destination.
- R4: `in_ready` is 0 in MODE_LO and MODE_FLUSH. In MODE_HI, a low-priority instruction is held off while the buffer is full or `fl_valid` is 0. High-priority and flush instructions are always accepted in MODE_HI.
- R5: In MODE_HI, if `miss_pend` rises (0 in the previous cycle, 1 now) while the buffer is non-empty and no flush is accepted, the next mode is 1 (MODE_LO).
- R6: In MODE_LO with `miss_pend`=1, the oldest entry issues each cycle with `iss_lo`=1 and its recorded registers. The same cycle asserts `rel_valid` with `rel_preg` equal to the entry's previous destination mapping. Entries leave in strict arrival order.
- R7: In MODE_LO, if `miss_pend` is 0, nothing issues and the next mode is MODE_HI.
- R8: When the last entry issues in MODE_LO while the miss is still pending, the next mode is MODE_HI. The controller stays in MODE_HI until the miss input rises again.
- R9: An accepted flush (`in_flush`=1) is never issued. With a non-empty buffer it moves the mode to 2 (MODE_FLUSH). That mode issues one entry per cycle whatever `miss_pend` is, and returns to MODE_HI after the last entry. With an empty buffer the flush has no effect.
- R10: The buffer holds exactly DEPTH (default 100) entries. The instruction after the DEPTH-th is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Decoded instruction accepted |
| in_hi | input | 1 | Priority tag, 1 = high priority |
| in_flush | input | 1 | Instruction is a flush (overrides tag) |
| in_dst | input | AREG_W | Architectural destination |
| in_src | input | AREG_W | Architectural source |
| miss_pend | input | 1 | Data-cache miss outstanding |
| fl_valid | input | 1 | Free list offers a register |
| fl_preg | input | PREG_W | Offered physical register |
| fl_take | output | 1 | Offered register consumed |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_lo | output | 1 | Issued instruction came from the buffer |
| iss_dst_p | output | PREG_W | Issued destination physical register |
| iss_src_p | output | PREG_W | Issued source physical register |
| rel_valid | output | 1 | Physical register returned to free list |
| rel_preg | output | PREG_W | Returned physical register |
| mode_o | output | 2 | 0 MODE_HI, 1 MODE_LO, 2 MODE_FLUSH |

## Verification
The scheduler is first driven with directed sequences, then with seeded random streams.
- Filling the buffer to DEPTH and flushing it separates the capacity limit from the flush drain.
- Two parked entries under a held miss separate the LO_EMPTY return from the LO_MISS_DONE return, and show that no re-entry happens without a new miss edge.
- The random streams mix tags, flushes, missing free registers and toggling misses over a small register set. Rename aliasing is therefore frequent, which tests whether high-priority reads see pending mappings and whether entries keep arrival order.

// File: rtl/pds_pkg.sv
package pds_pkg;
    typedef enum logic [1:0] {
        MODE_HI    = 2'd0,
        MODE_LO    = 2'd1,
        MODE_FLUSH = 2'd2
    } mode_e;
endpackage

// File: rtl/pds_rename_map.sv
module pds_rename_map #(
    parameter int NAREG  = 16,
    parameter int AREG_W = 4,
    parameter int PREG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREG_W-1:0] rd0_a,
    output logic [PREG_W-1:0] rd0_p,
    input  logic [AREG_W-1:0] rd1_a,
    output logic [PREG_W-1:0] rd1_p,
    input  logic              we,
    input  logic [AREG_W-1:0] wa,
    input  logic [PREG_W-1:0] wp
);
    logic [PREG_W-1:0] map_q [NAREG];

    // Each architectural register has its own mapping slot.
    for (genvar g = 0; g < NAREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[g] <= PREG_W'(g);
            end else if (we && (wa == AREG_W'(g))) begin
                map_q[g] <= wp;
            end
        end
    end

    assign rd0_p = map_q[rd0_a];
    assign rd1_p = map_q[rd1_a];
endmodule

// File: rtl/pds_defer_fifo.sv
module pds_defer_fifo #(
    parameter int DEPTH = 100,
    parameter int W     = 18,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic             last,
    output logic [CNT_W-1:0] occ
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign last  = (cnt == CNT_W'(1));
    assign occ   = cnt;
endmodule

// File: rtl/pds_mode_fsm.sv
module pds_mode_fsm
    import pds_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  miss_pend,
    input  logic  flush_acc,
    input  logic  empty,
    input  logic  last,
    output mode_e state,
    output logic  drain_en,
    output logic  hi_mode
);
    mode_e nxt;
    logic  miss_q;
    logic  miss_rise;

    assign miss_rise = miss_pend && !miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MODE_HI;
            miss_q <= 1'b0;
        end else begin
            state  <= nxt;
            miss_q <= miss_pend;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            MODE_HI: begin
                if (flush_acc && !empty)      nxt = MODE_FLUSH; // HI_TO_FLUSH
                else if (miss_rise && !empty) nxt = MODE_LO;    // HI_TO_LO
            end
            MODE_LO: begin
                if (!miss_pend) nxt = MODE_HI;                  // LO_MISS_DONE
                else if (last)  nxt = MODE_HI;                  // LO_EMPTY
            end
            MODE_FLUSH: begin
                if (last) nxt = MODE_HI;                        // FLUSH_DONE
            end
            default: nxt = MODE_HI;
        endcase
    end

    always_comb begin
        hi_mode  = 1'b0;
        drain_en = 1'b0;
        unique case (state)
            MODE_HI:    hi_mode  = 1'b1;
            MODE_LO:    drain_en = miss_pend;
            MODE_FLUSH: drain_en = 1'b1;
            default:    hi_mode  = 1'b0;
        endcase
    end
endmodule

// File: rtl/prio_defer_sched.sv
module prio_defer_sched #(
    parameter int NAREG = 16,
    parameter int NPREG = 64,
    parameter int DEPTH = 100,
    localparam int AREG_W = $clog2(NAREG),
    localparam int PREG_W = $clog2(NPREG),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ENT_W  = 3 * PREG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_hi,
    input  logic              in_flush,
    input  logic [AREG_W-1:0] in_dst,
    input  logic [AREG_W-1:0] in_src,
    input  logic              miss_pend,
    input  logic              fl_valid,
    input  logic [PREG_W-1:0] fl_preg,
    output logic              fl_take,
    output logic              iss_valid,
    output logic              iss_lo,
    output logic [PREG_W-1:0] iss_dst_p,
    output logic [PREG_W-1:0] iss_src_p,
    output logic              rel_valid,
    output logic [PREG_W-1:0] rel_preg,
    output logic [1:0]        mode_o
);
    import pds_pkg::*;

    mode_e             state;
    logic              drain_en, hi_mode;
    logic              empty, full, last;
    logic [CNT_W-1:0]  occ;
    logic [ENT_W-1:0]  head, wdata;
    logic [PREG_W-1:0] src_map, dst_map;
    logic              acc, flush_acc, lo_acc, hi_acc, pop;

    // Acceptance: only in MODE_HI; low-priority work needs space and a free register.
    always_comb begin
        in_ready = 1'b0;
        if (hi_mode) begin
            if (in_flush || in_hi) in_ready = 1'b1;
            else                   in_ready = !full && fl_valid;
        end
    end

    assign acc       = in_valid && in_ready;
    assign flush_acc = acc && in_flush;
    assign hi_acc    = acc && !in_flush && in_hi;
    assign lo_acc    = acc && !in_flush && !in_hi;
    assign pop       = drain_en && !empty;
    assign fl_take   = lo_acc;

    pds_rename_map #(.NAREG(NAREG), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .rd0_a (in_src),
        .rd0_p (src_map),
        .rd1_a (in_dst),
        .rd1_p (dst_map),
        .we    (lo_acc),
        .wa    (in_dst),
        .wp    (fl_preg)
    );

    // Entry layout: {new dst, captured src, previous dst mapping}.
    assign wdata = {fl_preg, src_map, dst_map};

    pds_defer_fifo #(.DEPTH(DEPTH), .W(ENT_W), .CNT_W(CNT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (lo_acc),
        .wdata (wdata),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .full  (full),
        .last  (last),
        .occ   (occ)
    );

    pds_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_pend (miss_pend),
        .flush_acc (flush_acc),
        .empty     (empty),
        .last      (last),
        .state     (state),
        .drain_en  (drain_en),
        .hi_mode   (hi_mode)
    );

    always_comb begin
        iss_valid = 1'b0;
        iss_lo    = 1'b0;
        iss_dst_p = dst_map;
        iss_src_p = src_map;
        rel_valid = 1'b0;
        rel_preg  = head[PREG_W-1:0];
        if (pop) begin
            iss_valid = 1'b1;
            iss_lo    = 1'b1;
            iss_dst_p = head[3*PREG_W-1:2*PREG_W];
            iss_src_p = head[2*PREG_W-1:PREG_W];
            rel_valid = 1'b1;
        end else if (hi_acc) begin
            iss_valid = 1'b1;
        end
    end

    assign mode_o = state;
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
    parameter int DEPTH = 100,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_o,
    input logic             in_valid,
    input logic             in_flush,
    input logic             in_ready,
    input logic             iss_valid,
    input logic             iss_lo,
    input logic             miss_pend,
    input logic             fl_take,
    input logic             fl_valid,
    input logic [CNT_W-1:0] occ
);
    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0) |-> !in_ready);

    p_take_needs_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_take |-> (fl_valid && in_ready && in_valid));

    p_hi_no_buffered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |-> !iss_lo);

    p_enter_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && $rose(miss_pend) && occ != '0 && !(in_valid && in_flush))
        |=> (mode_o == 2'd1));

    p_lo_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && !miss_pend) |=> (mode_o == 2'd0));

    p_flush_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (iss_valid && iss_lo));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
endmodule

bind prio_defer_sched pds_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_o    (mode_o),
    .in_valid  (in_valid),
    .in_flush  (in_flush),
    .in_ready  (in_ready),
    .iss_valid (iss_valid),
    .iss_lo    (iss_lo),
    .miss_pend (miss_pend),
    .fl_take   (fl_take),
    .fl_valid  (fl_valid),
    .occ       (occ)
);

// File: tb/prio_defer_sched_tb.sv
module prio_defer_sched_tb;
    localparam int NAREG = 16;
    localparam int NPREG = 64;
    localparam int DEPTH = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_hi, in_flush, miss_pend, fl_valid;
    logic [3:0] in_dst, in_src;
    logic [5:0] fl_preg;
    logic       in_ready, fl_take, iss_valid, iss_lo, rel_valid;
    logic [5:0] iss_dst_p, iss_src_p, rel_preg;
    logic [1:0] mode_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state kept by the bench.
    int         mst;
    bit         mmiss;
    logic [5:0] mtab [NAREG];
    logic [17:0] mq [$];

    always #5 clk = ~clk;

    prio_defer_sched #(.NAREG(NAREG), .NPREG(NPREG), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hi(in_hi), .in_flush(in_flush), .in_dst(in_dst), .in_src(in_src),
        .miss_pend(miss_pend), .fl_valid(fl_valid), .fl_preg(fl_preg),
        .fl_take(fl_take), .iss_valid(iss_valid), .iss_lo(iss_lo),
        .iss_dst_p(iss_dst_p), .iss_src_p(iss_src_p), .rel_valid(rel_valid),
        .rel_preg(rel_preg), .mode_o(mode_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int s);
        return (s == 0) ? "R5" : (s == 1) ? "R7" : "R9";
    endfunction

    task automatic model_reset();
        mst = 0;
        mmiss = 1'b0;
        mq.delete();
        for (int i = 0; i < NAREG; i++) mtab[i] = 6'(i);
    endtask

    // One cycle: drive, compare outputs against the model, then advance the model.
    task automatic step(input bit v, input bit hi, input bit fl, input logic [3:0] d,
                        input logic [3:0] s, input bit miss, input bit flv, input logic [5:0] fp);
        bit rdy, acc, ev, drain;
        int sz;
        logic [17:0] hd;
        in_valid = v; in_hi = hi; in_flush = fl; in_dst = d; in_src = s;
        miss_pend = miss; fl_valid = flv; fl_preg = fp;
        #2;
        sz  = mq.size();
        rdy = (mst == 0) && (fl || hi || (sz < DEPTH && flv));
        acc = v && rdy;
        chk("R4", "in_ready", in_ready, rdy);
        chk(mode_tag(mst), "mode", mode_o, mst);
        chk("R3", "fl_take", fl_take, acc && !fl && !hi);
        drain = ((mst == 1) && miss) || (mst == 2);
        if (mst == 0) begin
            ev = acc && hi && !fl;
            chk("R2", "iss_valid", iss_valid, ev);
            chk("R2", "iss_lo", iss_lo, 0);
            chk("R6", "rel_valid", rel_valid, 0);
            if (ev) begin
                chk("R2", "iss_dst_p", iss_dst_p, mtab[d]);
                chk("R2", "iss_src_p", iss_src_p, mtab[s]);
            end
        end else begin
            ev = drain && sz > 0;
            chk((mst == 2) ? "R9" : "R6", "iss_valid", iss_valid, ev);
            chk("R6", "rel_valid", rel_valid, ev);
            if (ev) begin
                hd = mq[0];
                chk("R6", "iss_lo", iss_lo, 1);
                chk("R6", "iss_dst_p", iss_dst_p, hd[17:12]);
                chk("R6", "iss_src_p", iss_src_p, hd[11:6]);
                chk("R6", "rel_preg", rel_preg, hd[5:0]);
            end
        end
        @(posedge clk);
        if (mst == 0) begin
            if (acc && !fl && !hi) begin
                mq.push_back({fp, mtab[s], mtab[d]});
                mtab[d] = fp;
            end
            if (acc && fl && sz > 0)          mst = 2;
            else if (miss && !mmiss && sz > 0) mst = 1;
        end else if (mst == 1) begin
            if (!miss) mst = 0;
            else begin
                void'(mq.pop_front());
                if (sz == 1) mst = 0;
            end
        end else begin
            void'(mq.pop_front());
            if (sz == 1) mst = 0;
        end
        mmiss = miss;
        @(negedge clk);
    endtask

    task automatic idle(input bit miss);
        step(0, 0, 0, 4'd0, 4'd0, miss, 1, 6'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 0; in_hi = 0; in_flush = 0; in_dst = 0; in_src = 0;
        miss_pend = 0; fl_valid = 1; fl_preg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R1: reset state.
        in_valid = 1; in_hi = 0; fl_valid = 1;
        #2;
        chk("R1", "mode after reset", mode_o, 0);
        chk("R1", "no issue after reset", iss_valid, 0);
        chk("R1", "ready with empty buffer", in_ready, 1);
        in_valid = 0;
        @(negedge clk);

        // R2/R3: high-priority read sees a pending low-priority mapping.
        step(1, 1, 0, 4'd3, 4'd5, 0, 1, 6'd0);       // identity map
        step(1, 0, 0, 4'd5, 4'd5, 0, 1, 6'd40);      // r5 -> p40, src reads p5
        step(1, 1, 0, 4'd7, 4'd5, 0, 1, 6'd0);
        step(1, 0, 0, 4'd2, 4'd9, 0, 0, 6'd41);      // no free register: R4 stall

        // R8: drain empties while miss stays pending.
        step(0, 0, 0, 4'd0, 4'd0, 1, 1, 6'd0);       // miss rises -> MODE_LO
        idle(1);                                     // issues the only entry
        chk("R8", "mode after last entry", mode_o, 0);
        idle(1);
        idle(1);
        chk("R8", "no re-entry without new miss edge", mode_o, 0);
        step(1, 0, 0, 4'd1, 4'd2, 1, 1, 6'd42);
        idle(1);
        chk("R8", "still high mode with entry parked", mode_o, 0);
        idle(0);
        step(0, 0, 0, 4'd0, 4'd0, 1, 1, 6'd0);
        chk("R5", "mode after miss edge", mode_o, 1);
        idle(0);                                     // LO_MISS_DONE, entry stays
        chk("R7", "mode after miss clears", mode_o, 0);

        // R9: flush with an empty buffer has no effect.
        do_reset();
        step(1, 0, 1, 4'd0, 4'd0, 0, 1, 6'd0);
        chk("R9", "flush on empty buffer", mode_o, 0);

        // R10: fill to DEPTH, next is held off, flush drains everything.
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 0, 4'(i % NAREG), 4'((i + 3) % NAREG), 0, 1, 6'((i % 48) + 16));
        in_valid = 1; in_hi = 0; in_flush = 0; fl_valid = 1;
        #2;
        chk("R10", "ready when buffer full", in_ready, 0);
        in_valid = 0;
        @(negedge clk);
        step(1, 0, 1, 4'd0, 4'd0, 0, 1, 6'd0);
        chk("R9", "mode after flush", mode_o, 2);
        for (int i = 0; i < DEPTH - 1; i++) idle(i % 2 == 0);
        chk("R10", "still draining before last entry", mode_o, 2);
        idle(0);
        chk("R9", "mode after full drain", mode_o, 0);

        // Random mix of tags, flushes, free-list gaps and miss toggles.
        do_reset();
        begin
            bit m = 0;
            for (int i = 0; i < 6000; i++) begin
                int r = $urandom_range(0, 99);
                if ($urandom_range(0, 9) == 0) m = !m;
                step($urandom_range(0, 9) < 8, r < 45, r >= 97,
                     4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                     m, $urandom_range(0, 9) != 0, 6'($urandom_range(16, 63)));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule